// File: doc/BRIEF.md
# Packed Quotient-Remainder Divider

This block is a sequential integer divider. It divides a double-width dividend by a single-width divisor, one quotient bit per clock. The quotient and the remainder come back together in one double-width word, which can be written straight back to the register that held the dividend. A mode input picks the narrow form or the wide form. The narrow form divides a 2*BYTE_W-bit dividend by a BYTE_W-bit divisor. The wide form divides a 4*BYTE_W-bit dividend by a 2*BYTE_W-bit divisor. A second input chooses between two's-complement and unsigned operands.

The caller raises `start` for one cycle, with the operands and the modes on the inputs. The block captures everything it needs in that cycle. A one-cycle `done` pulse marks the result and the two flags as valid. Those outputs then hold until the next division completes. A zero divisor does not fault. The block reports it through the zero flag and hands back the dividend unchanged.

Top module: `pqr_divider`

## Requirements
- R1: In narrow mode (`word_mode`=0), `dividend[15:0]` is divided by `divisor[7:0]`. The result has the quotient in bits 7:0, the remainder in bits 15:8, and zeros in bits 31:16.
- R2: In wide mode (`word_mode`=1), `dividend[31:0]` is divided by `divisor[15:0]`. The result has the quotient in bits 15:0 and the remainder in bits 31:16.
- R3: With `signed_mode`=1, both operands are read as two's-complement numbers of their active width, and the quotient is truncated toward zero.
- R4: With `signed_mode`=1, the remainder has the sign of the dividend (or is zero), and dividend = quotient*divisor + remainder.
- R5: `flag_n` equals the top bit of the quotient field: bit 7 in narrow mode, bit 15 in wide mode.
- R6: `flag_z` is 1 exactly when the active divisor bits are all zero. In that case `flag_n` is 0 and the result is the dividend: the full 32 bits in wide mode, or `dividend[15:0]` with zero upper bits in narrow mode.
- R7: `done` is high for exactly one cycle. Counting from the clock edge that accepts `start`, that cycle comes after 18 edges in narrow mode, after 34 in wide mode, and after 2 for a zero divisor.
- R8: A `start` that arrives while a division is in progress is ignored. The running division still ends at its own time, with its own result.
- R9: After reset, `done`, `flag_n`, `flag_z` and `result` are all zero.
- R10: If the true quotient does not fit its field, the field holds the low bits of the truncated quotient.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a division when idle |
| word_mode | input | 1 | 0 selects narrow operands, 1 selects wide operands |
| signed_mode | input | 1 | 1 selects two's-complement operands |
| dividend | input | 32 | Dividend; narrow mode uses the low 16 bits |
| divisor | input | 16 | Divisor; narrow mode uses the low 8 bits |
| result | output | 32 | Packed remainder (upper field) and quotient (lower field) |
| flag_n | output | 1 | Sign bit of the quotient field |
| flag_z | output | 1 | Divisor was zero |
| done | output | 1 | One-cycle completion pulse |

## Verification
The stimulus covers all four sign combinations of dividend and divisor in both widths. This shows whether the sign correction is applied to the quotient and the remainder independently, and whether the remainder follows the dividend rather than the divisor. Unsigned operands with the top bit set show whether an operand is sign-extended when it should not be. The most negative dividend divided by minus one, and a wide dividend divided by one, exercise quotients too large for their field and show that the low bits are kept. A zero narrow divisor paired with non-zero upper divisor bits shows that only the active width is tested. A second start during a running division, with different operands and modes, shows whether the captured operands are protected.

// File: rtl/pqr_pkg.sv
package pqr_pkg;
   typedef enum logic [1:0] {
      PQR_IDLE = 2'd0,
      PQR_RUN  = 2'd1,
      PQR_FIN  = 2'd2
   } pqr_state_e;
endpackage

// File: rtl/pqr_operand_prep.sv
module pqr_operand_prep #(
   parameter int BYTE_W = 8
) (
   input  logic                  word_mode,
   input  logic                  signed_mode,
   input  logic [4*BYTE_W-1:0]   dividend,
   input  logic [2*BYTE_W-1:0]   divisor,
   output logic [4*BYTE_W-1:0]   dvd_mag,
   output logic [2*BYTE_W-1:0]   dvs_mag,
   output logic                  quo_neg,
   output logic                  rem_neg,
   output logic                  dvs_zero
);
   localparam int HALF_W = 2 * BYTE_W;
   localparam int FULL_W = 4 * BYTE_W;

   logic [FULL_W-1:0] dvd_ext;
   logic [HALF_W-1:0] dvs_ext;
   logic              dvd_sign;
   logic              dvs_sign;

   // sign-extend the active operand widths into the common datapath width
   always_comb begin
      if (word_mode) begin
         dvd_sign = signed_mode & dividend[FULL_W-1];
         dvs_sign = signed_mode & divisor[HALF_W-1];
         dvd_ext  = dividend;
         dvs_ext  = divisor;
      end else begin
         dvd_sign = signed_mode & dividend[HALF_W-1];
         dvs_sign = signed_mode & divisor[BYTE_W-1];
         dvd_ext  = {{HALF_W{dvd_sign}}, dividend[HALF_W-1:0]};
         dvs_ext  = {{BYTE_W{dvs_sign}}, divisor[BYTE_W-1:0]};
      end
   end

   // magnitudes feed the unsigned core; the signs are kept for the fix-up
   assign dvd_mag  = dvd_sign ? -dvd_ext : dvd_ext;
   assign dvs_mag  = dvs_sign ? -dvs_ext : dvs_ext;
   assign quo_neg  = dvd_sign ^ dvs_sign;
   assign rem_neg  = dvd_sign;
   assign dvs_zero = (dvs_ext == '0);
endmodule

// File: rtl/pqr_restore_core.sv
module pqr_restore_core #(
   parameter int DVD_W = 32,
   parameter int DVS_W = 16,
   parameter int CNT_W = 6
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic               load,
   input  logic [DVD_W-1:0]   load_dvd,
   input  logic [DVS_W-1:0]   load_dvs,
   input  logic [CNT_W-1:0]   load_iters,
   output logic               last_step,
   output logic [DVS_W-1:0]   quo_low,
   output logic [DVS_W-1:0]   rem
);
   logic [DVD_W-1:0] quo_q;
   logic [DVS_W-1:0] rem_q;
   logic [DVS_W-1:0] dvs_q;
   logic [CNT_W-1:0] cnt_q;

   logic [DVS_W:0]   rem_shift;
   logic [DVS_W:0]   rem_diff;
   logic [DVS_W:0]   rem_next;
   logic             fits;

   // one restoring step: shift in the next dividend bit, subtract if it fits
   always_comb begin
      rem_shift = {rem_q, quo_q[DVD_W-1]};
      fits      = (rem_shift >= {1'b0, dvs_q});
      rem_diff  = rem_shift - {1'b0, dvs_q};
      rem_next  = fits ? rem_diff : rem_shift;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         quo_q <= '0;
         rem_q <= '0;
         dvs_q <= '0;
         cnt_q <= '0;
      end else if (load) begin
         quo_q <= load_dvd;
         rem_q <= '0;
         dvs_q <= load_dvs;
         cnt_q <= load_iters;
      end else if (cnt_q != '0) begin
         rem_q <= rem_next[DVS_W-1:0];
         quo_q <= {quo_q[DVD_W-2:0], fits};
         cnt_q <= cnt_q - 1'b1;
      end
   end

   assign last_step = (cnt_q == CNT_W'(1));
   assign quo_low   = quo_q[DVS_W-1:0];
   assign rem       = rem_q;

   // partial remainder always fits the divisor width after a step
   assert_rem_fits_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_q != '0) |-> !rem_next[DVS_W]);

   // final remainder magnitude is below the divisor magnitude
   assert_rem_below_divisor_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (last_step && !load) |=> (rem_q < dvs_q));
endmodule

// File: rtl/pqr_result_pack.sv
module pqr_result_pack #(
   parameter int BYTE_W = 8
) (
   input  logic                  word_mode,
   input  logic                  quo_neg,
   input  logic                  rem_neg,
   input  logic [2*BYTE_W-1:0]   quo_mag,
   input  logic [2*BYTE_W-1:0]   rem_mag,
   output logic [4*BYTE_W-1:0]   packed_val,
   output logic                  quo_sign
);
   localparam int HALF_W = 2 * BYTE_W;

   logic [HALF_W-1:0] quo_fix;
   logic [HALF_W-1:0] rem_fix;

   assign quo_fix = quo_neg ? -quo_mag : quo_mag;
   assign rem_fix = rem_neg ? -rem_mag : rem_mag;

   // remainder in the upper field, quotient in the lower field
   always_comb begin
      if (word_mode) begin
         packed_val = {rem_fix, quo_fix};
         quo_sign   = quo_fix[HALF_W-1];
      end else begin
         packed_val = {{HALF_W{1'b0}}, rem_fix[BYTE_W-1:0], quo_fix[BYTE_W-1:0]};
         quo_sign   = quo_fix[BYTE_W-1];
      end
   end
endmodule

// File: rtl/pqr_divider.sv
module pqr_divider
   import pqr_pkg::*;
#(
   parameter int BYTE_W = 8
) (
   input  logic                  clk,
   input  logic                  rst_n,
   input  logic                  start,
   input  logic                  word_mode,
   input  logic                  signed_mode,
   input  logic [4*BYTE_W-1:0]   dividend,
   input  logic [2*BYTE_W-1:0]   divisor,
   output logic [4*BYTE_W-1:0]   result,
   output logic                  flag_n,
   output logic                  flag_z,
   output logic                  done
);
   localparam int HALF_W = 2 * BYTE_W;
   localparam int FULL_W = 4 * BYTE_W;
   localparam int ITER_W = $clog2(FULL_W + 1);
   localparam logic [ITER_W-1:0] WIDE_ITERS   = ITER_W'(FULL_W);
   localparam logic [ITER_W-1:0] NARROW_ITERS = ITER_W'(HALF_W);

   if (BYTE_W < 2) begin : g_width_check
      $error("pqr_divider: BYTE_W must be at least 2");
   end

   pqr_state_e        state_q;
   logic              word_q;
   logic              quo_neg_q;
   logic              rem_neg_q;
   logic              zero_q;
   logic [FULL_W-1:0] keep_q;
   logic [FULL_W-1:0] result_q;
   logic              n_q;
   logic              z_q;
   logic              done_q;

   logic [FULL_W-1:0] dvd_mag;
   logic [HALF_W-1:0] dvs_mag;
   logic              quo_neg_c;
   logic              rem_neg_c;
   logic              dvs_zero_c;
   logic              accept;
   logic [FULL_W-1:0] load_dvd;
   logic [ITER_W-1:0] load_iters;
   logic              core_last;
   logic [HALF_W-1:0] core_quo;
   logic [HALF_W-1:0] core_rem;
   logic [FULL_W-1:0] packed_val;
   logic              pack_sign;

   assign accept = start && (state_q == PQR_IDLE);

   pqr_operand_prep #(.BYTE_W(BYTE_W)) u_prep (
      .word_mode   (word_mode),
      .signed_mode (signed_mode),
      .dividend    (dividend),
      .divisor     (divisor),
      .dvd_mag     (dvd_mag),
      .dvs_mag     (dvs_mag),
      .quo_neg     (quo_neg_c),
      .rem_neg     (rem_neg_c),
      .dvs_zero    (dvs_zero_c)
   );

   // narrow dividends are left-aligned so the core always shifts from its top bit
   assign load_dvd   = word_mode ? dvd_mag : {dvd_mag[HALF_W-1:0], {HALF_W{1'b0}}};
   assign load_iters = word_mode ? WIDE_ITERS : NARROW_ITERS;

   pqr_restore_core #(
      .DVD_W (FULL_W),
      .DVS_W (HALF_W),
      .CNT_W (ITER_W)
   ) u_core (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept && !dvs_zero_c),
      .load_dvd   (load_dvd),
      .load_dvs   (dvs_mag),
      .load_iters (load_iters),
      .last_step  (core_last),
      .quo_low    (core_quo),
      .rem        (core_rem)
   );

   pqr_result_pack #(.BYTE_W(BYTE_W)) u_pack (
      .word_mode  (word_q),
      .quo_neg    (quo_neg_q),
      .rem_neg    (rem_neg_q),
      .quo_mag    (core_quo),
      .rem_mag    (core_rem),
      .packed_val (packed_val),
      .quo_sign   (pack_sign)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q   <= PQR_IDLE;
         word_q    <= 1'b0;
         quo_neg_q <= 1'b0;
         rem_neg_q <= 1'b0;
         zero_q    <= 1'b0;
         keep_q    <= '0;
         result_q  <= '0;
         n_q       <= 1'b0;
         z_q       <= 1'b0;
         done_q    <= 1'b0;
      end else begin
         done_q <= 1'b0;
         unique case (state_q)
            PQR_IDLE: begin
               if (accept) begin
                  word_q    <= word_mode;
                  quo_neg_q <= quo_neg_c;
                  rem_neg_q <= rem_neg_c;
                  zero_q    <= dvs_zero_c;
                  keep_q    <= word_mode ? dividend
                                         : {{HALF_W{1'b0}}, dividend[HALF_W-1:0]};
                  state_q   <= dvs_zero_c ? PQR_FIN : PQR_RUN;
               end
            end
            PQR_RUN: begin
               if (core_last) state_q <= PQR_FIN;
            end
            PQR_FIN: begin
               done_q  <= 1'b1;
               state_q <= PQR_IDLE;
               if (zero_q) begin
                  result_q <= keep_q;
                  n_q      <= 1'b0;
                  z_q      <= 1'b1;
               end else begin
                  result_q <= packed_val;
                  n_q      <= pack_sign;
                  z_q      <= 1'b0;
               end
            end
            default: state_q <= PQR_IDLE;
         endcase
      end
   end

   assign result = result_q;
   assign flag_n = n_q;
   assign flag_z = z_q;
   assign done   = done_q;

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_ignore_start_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (start && state_q != PQR_IDLE) |=> ($stable(keep_q) && $stable(word_q)));

   assert_narrow_upper_zero_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (done && !word_q) |-> (result[FULL_W-1:HALF_W] == '0));

   assert_zero_clears_n_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (done && flag_z) |-> !flag_n);
endmodule

// File: tb/pqr_divider_bench.sv
`timescale 1ns/1ps
module pqr_divider_bench;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        start = 1'b0;
   logic        word_mode = 1'b0;
   logic        signed_mode = 1'b0;
   logic [31:0] dividend = '0;
   logic [15:0] divisor = '0;
   logic [31:0] result;
   logic        flag_n;
   logic        flag_z;
   logic        done;

   int checks = 0;
   int fails = 0;
   int cyc = 0;

   always #5 clk = ~clk;

   pqr_divider #(.BYTE_W(8)) u_pqr_divider (
      .clk         (clk),
      .rst_n       (rst_n),
      .start       (start),
      .word_mode   (word_mode),
      .signed_mode (signed_mode),
      .dividend    (dividend),
      .divisor     (divisor),
      .result      (result),
      .flag_n      (flag_n),
      .flag_z      (flag_z),
      .done        (done)
   );

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         fails++;
         $display("FAIL R7 watchdog: actual no completion expected finish before %0d cycles", cyc);
         $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
         $finish;
      end
   end

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
      end
   endtask

   // reference: truncating division on wide integers, compared every clock
   task automatic run_div(string tag, bit wm, bit sm, logic [31:0] dvd,
                          logic [15:0] dvs, bit intrude);
      longint a, b, q, r;
      logic [31:0] exp_res;
      bit exp_n, exp_z;
      int lat;
      if (wm) begin
         a = sm ? longint'($signed(dvd)) : longint'(dvd);
         b = sm ? longint'($signed(dvs)) : longint'(dvs);
      end else begin
         a = sm ? longint'($signed(dvd[15:0])) : longint'(dvd[15:0]);
         b = sm ? longint'($signed(dvs[7:0])) : longint'(dvs[7:0]);
      end
      if (b == 0) begin
         exp_z = 1'b1;
         exp_n = 1'b0;
         exp_res = wm ? dvd : {16'h0, dvd[15:0]};
         lat = 2;
      end else begin
         q = a / b;
         r = a % b;
         exp_z = 1'b0;
         if (wm) begin
            exp_res = {r[15:0], q[15:0]};
            exp_n = q[15];
            lat = 34;
         end else begin
            exp_res = {16'h0, r[7:0], q[7:0]};
            exp_n = q[7];
            lat = 18;
         end
      end
      @(negedge clk);
      start = 1'b1;
      word_mode = wm;
      signed_mode = sm;
      dividend = dvd;
      divisor = dvs;
      for (int n = 1; n <= lat; n++) begin
         @(posedge clk);
         #1;
         if (n == 1) start = 1'b0;
         if (intrude && n == 3) begin
            start = 1'b1;
            word_mode = ~wm;
            signed_mode = ~sm;
            dividend = ~dvd;
            divisor = dvs + 16'd3;
         end
         if (intrude && n == 4) start = 1'b0;
         chk("R7", "done", {31'h0, done}, {31'h0, (n == lat)});
         if (n == lat) begin
            chk(tag, "result", result, exp_res);
            chk("R5", "flag_n", {31'h0, flag_n}, {31'h0, exp_n});
            chk("R6", "flag_z", {31'h0, flag_z}, {31'h0, exp_z});
         end
      end
      @(posedge clk);
      #1;
      chk("R7", "done after pulse", {31'h0, done}, 32'h0);
   endtask

   initial begin
      repeat (3) @(posedge clk);
      #1;
      chk("R9", "reset result", result, 32'h0);
      chk("R9", "reset done", {31'h0, done}, 32'h0);
      chk("R9", "reset flag_n", {31'h0, flag_n}, 32'h0);
      chk("R9", "reset flag_z", {31'h0, flag_z}, 32'h0);
      rst_n = 1'b1;

      // R1 narrow unsigned
      run_div("R1", 0, 0, 32'hABCD_03E8, 16'hFF07, 0);
      run_div("R1", 0, 0, 32'h0000_00FF, 16'h0010, 0);
      run_div("R1", 0, 0, 32'h0000_C350, 16'h00C8, 0);
      // R2 wide unsigned
      run_div("R2", 1, 0, 32'd100000, 16'd300, 0);
      run_div("R2", 1, 0, 32'hFFFF_FFFF, 16'hFFFF, 0);
      run_div("R2", 1, 0, 32'h0003_0001, 16'h8001, 0);
      // R3 R4 signed, all sign pairs, both widths
      run_div("R3,R4", 0, 1, 32'h0000_FFF9, 16'h0002, 0);
      run_div("R3,R4", 0, 1, 32'h0000_0007, 16'h00FE, 0);
      run_div("R3,R4", 0, 1, 32'h0000_FFF9, 16'h00FE, 0);
      run_div("R3,R4", 0, 1, 32'h0000_0007, 16'h0002, 0);
      run_div("R3,R4", 0, 1, 32'h0000_0064, 16'h00FD, 0);
      run_div("R3,R4", 1, 1, -32'sd100000, 16'd7, 0);
      run_div("R3,R4", 1, 1, 32'd100000, -16'sd7, 0);
      run_div("R3,R4", 1, 1, -32'sd100000, -16'sd7, 0);
      run_div("R3,R4", 1, 1, 32'd100000, 16'd7, 0);
      run_div("R3,R4", 1, 1, -32'sd9, 16'd4, 0);
      // R10 quotient wider than its field
      run_div("R10", 0, 0, 32'h0000_FFFF, 16'h0001, 0);
      run_div("R10", 0, 1, 32'h0000_8000, 16'h00FF, 0);
      run_div("R10", 1, 0, 32'h1234_5678, 16'h0001, 0);
      run_div("R10", 1, 1, 32'h8000_0000, 16'hFFFF, 0);
      // R6 zero divisor, only the active bits count
      run_div("R6", 0, 0, 32'hDEAD_BEEF, 16'h5A00, 0);
      run_div("R6", 1, 1, 32'hCAFE_1234, 16'h0000, 0);
      run_div("R6", 0, 1, 32'h1111_8001, 16'h0000, 0);
      // R8 start during a running division
      run_div("R8", 1, 0, 32'd987654, 16'd321, 1);
      run_div("R8", 0, 1, 32'h0000_FF38, 16'h0005, 1);

      for (int i = 0; i < 60; i++) begin
         bit wm, sm;
         logic [31:0] dvd;
         logic [15:0] dvs;
         wm = bit'($urandom % 2);
         sm = bit'($urandom % 2);
         dvd = $urandom;
         dvs = 16'($urandom);
         if (dvs[7:0] == 8'h0) dvs[0] = 1'b1;
         run_div(sm ? "R3,R4" : (wm ? "R2" : "R1"), wm, sm, dvd, dvs, 0);
      end

      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
   end
endmodule